// File: doc/BRIEF.md
# Device Power State Controller

This block follows the power state of a network function attached to a host bus. It has four states: a reset state, an active state that is not yet initialized, a fully active state, and a low-power state. The reset state acts like the low-power state, with one difference: it also asks the bus pads to float. The block moves between states in response to a bus reset, a power-good signal, the memory-access enable and writes to a 2-bit power-state field. The field reads back a compressed form of the current state.

The block also holds the wake-enable and wake-status bits. Software can reach these bits through two views: the power-management control/status view and a wakeup-control shadow view. An auxiliary-power strap sets whether a bus reset wipes these bits. The same strap drives a wake-capability advertisement for the unpowered low-power state. An enable input lets that unpowered state turn into a fully disabled condition. The configuration decoder that generates the write strobes sits outside the block, and so does the logic that detects wake packets.

Top module: `pwr_state_ctrl`

## Requirements
- R1: The `state` output encodes the reset state as 0, the uninitialized active state as 1, the active state as 2 and the low-power state as 3. While `rst_n` is low, the reset state (0) is shown and both wake bits read 0.
- R2: If `bus_rst_n` is sampled low, `state` is 0 after the next clock edge, whatever the state was before.
- R3: If `pwr_good` is sampled low, `state` is 0 after the next clock edge and both wake bits are cleared, whatever the value of `aux_pwr`.
- R4: In state 0, with `bus_rst_n` and `pwr_good` both high, the next clock edge moves the block to state 1.
- R5: In state 1, a high `mem_en` moves the block to state 2 on the next edge. In any other state, `mem_en` changes nothing.
- R6: In state 1 or 2, a write (`ps_wr`) of 2'b11 moves the block to state 3. In state 3, a write of 2'b00 moves it to state 1. Writes of 2'b01 or 2'b10 are ignored. `ps_rd` shows 2'b00 in states 1 and 2, and 2'b11 in states 0 and 3.
- R7: `bus_iso` is high exactly when the block is in state 0.
- R8: `wake_cap` equals `aux_pwr` combinationally, with no clock edge in between.
- R9: While `aux_pwr` is high, a bus reset pulse (low, then high again) leaves `wake_en` and `wake_sts` unchanged.
- R10: While `aux_pwr` is low, both wake bits are cleared on the clock edge that first samples `bus_rst_n` high after it was low. Holding `bus_rst_n` low does not clear them.
- R11: `wake_evt` sets `wake_sts`. Writing 1 to the status field in either view clears it, but a simultaneous event wins. Either view writes `wake_en`, and when both views write in the same cycle the control/status view wins.
- R12: `pme_req` is high exactly when both `wake_en` and `wake_sts` are high.
- R13: `lp_off` is high exactly when `deep_off_en` is high and the block is in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low core reset, released synchronously |
| pwr_good | input | 1 | Main power good; low acts as a power-on reset |
| bus_rst_n | input | 1 | Active-low bus reset, already synchronized to clk |
| aux_pwr | input | 1 | Auxiliary-power strap, level sensitive |
| deep_off_en | input | 1 | Permits the fully disabled condition in the reset state |
| mem_en | input | 1 | Memory-access enable bit |
| ps_wr | input | 1 | Write strobe for the power-state field |
| ps_wdata | input | 2 | Power-state write data |
| cfg_wr | input | 1 | Write strobe for the control/status view |
| cfg_en_wd | input | 1 | Wake-enable write data, control/status view |
| cfg_sts_w1c | input | 1 | Write-1-to-clear for wake status, control/status view |
| wuc_wr | input | 1 | Write strobe for the wakeup-control shadow view |
| wuc_en_wd | input | 1 | Wake-enable write data, shadow view |
| wuc_sts_w1c | input | 1 | Write-1-to-clear for wake status, shadow view |
| wake_evt | input | 1 | Single-cycle wake event from the detector |
| state | output | 2 | Current power state |
| ps_rd | output | 2 | Read-back value of the power-state field |
| bus_iso | output | 1 | Float the bus pads |
| wake_cap | output | 1 | Advertises wake from the unpowered low-power state |
| wake_en | output | 1 | Wake-enable bit (shared by both views) |
| wake_sts | output | 1 | Wake-status bit (shared by both views) |
| pme_req | output | 1 | Wake request |
| lp_off | output | 1 | Fully disabled low-power condition |

## Verification
The state machine is driven through every arc: bus reset from the low-power state, power loss, memory enable, and writes of all four field codes. These cases separate legal transitions from ignored writes, and they show that `mem_en` acts only in the uninitialized state. The wake bits go through the same bus reset pulse twice, once with auxiliary power high and once with it low, and each time they are checked both while reset is held and after it is released. This separates "kept" from "cleared on the rising edge" from "cleared on the level". Same-cycle writes through both views, and status-clear writes that collide with events, pin down the priority order.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  localparam int PS_W = 2;

  typedef enum logic [PS_W-1:0] {
    PS_DR  = 2'd0,
    PS_D0U = 2'd1,
    PS_D0A = 2'd2,
    PS_D3  = 2'd3
  } pstate_e;

  localparam logic [PS_W-1:0] PSF_ON  = 2'b00;
  localparam logic [PS_W-1:0] PSF_OFF = 2'b11;

endpackage

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_state_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_good,
  input  logic            bus_rst_n,
  input  logic            mem_en,
  input  logic            ps_wr,
  input  logic [PS_W-1:0] ps_wdata,
  output pstate_e         state_q,
  output logic [PS_W-1:0] ps_rd
);

  pstate_e state_d;
  logic    state_ce;
  logic    wr_off;
  logic    wr_on;

  assign wr_off = ps_wr && (ps_wdata == PSF_OFF);
  assign wr_on  = ps_wr && (ps_wdata == PSF_ON);

  always_comb begin
    state_d = state_q;
    if (!pwr_good || !bus_rst_n) begin
      state_d = PS_DR;
    end else begin
      unique case (state_q)
        PS_DR:   state_d = PS_D0U;
        PS_D0U:  if (wr_off) state_d = PS_D3;
                 else if (mem_en) state_d = PS_D0A;
        PS_D0A:  if (wr_off) state_d = PS_D3;
        PS_D3:   if (wr_on) state_d = PS_D0U;
        default: state_d = PS_DR;
      endcase
    end
  end

  assign state_ce = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= PS_DR;
    else if (state_ce) state_q <= state_d;
  end

  assign ps_rd = ((state_q == PS_D0U) || (state_q == PS_D0A)) ? PSF_ON : PSF_OFF;

endmodule

// File: rtl/pwr_wake_regs.sv
module pwr_wake_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic bus_rst_n,
  input  logic aux_pwr,
  input  logic cfg_wr,
  input  logic cfg_en_wd,
  input  logic cfg_sts_w1c,
  input  logic wuc_wr,
  input  logic wuc_en_wd,
  input  logic wuc_sts_w1c,
  input  logic wake_evt,
  output logic wake_en,
  output logic wake_sts,
  output logic pme_req
);

  logic bus_q;
  logic bus_rise;
  logic wipe;
  logic en_d, sts_d;
  logic en_ce, sts_ce;
  logic sts_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_q <= 1'b0;
    else        bus_q <= bus_rst_n;
  end

  assign bus_rise = bus_rst_n && !bus_q;
  assign wipe     = !pwr_good || (bus_rise && !aux_pwr);
  assign sts_clr  = (cfg_wr && cfg_sts_w1c) || (wuc_wr && wuc_sts_w1c);

  always_comb begin
    if (wipe)        en_d = 1'b0;
    else if (cfg_wr) en_d = cfg_en_wd;
    else if (wuc_wr) en_d = wuc_en_wd;
    else             en_d = wake_en;
  end

  always_comb begin
    if (wipe)          sts_d = 1'b0;
    else if (wake_evt) sts_d = 1'b1;
    else if (sts_clr)  sts_d = 1'b0;
    else               sts_d = wake_sts;
  end

  assign en_ce  = (en_d != wake_en);
  assign sts_ce = (sts_d != wake_sts);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wake_en <= 1'b0;
    else if (en_ce) wake_en <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wake_sts <= 1'b0;
    else if (sts_ce) wake_sts <= sts_d;
  end

  assign pme_req = wake_en && wake_sts;

endmodule

// File: rtl/pwr_adv.sv
module pwr_adv
  import pwr_state_pkg::*;
(
  input  pstate_e state_q,
  input  logic    aux_pwr,
  input  logic    deep_off_en,
  output logic    wake_cap,
  output logic    bus_iso,
  output logic    lp_off
);

  logic in_dr;

  assign in_dr    = (state_q == PS_DR);
  assign bus_iso  = in_dr;
  assign wake_cap = aux_pwr;
  assign lp_off   = deep_off_en && in_dr;

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_good,
  input  logic            bus_rst_n,
  input  logic            aux_pwr,
  input  logic            deep_off_en,
  input  logic            mem_en,
  input  logic            ps_wr,
  input  logic [PS_W-1:0] ps_wdata,
  input  logic            cfg_wr,
  input  logic            cfg_en_wd,
  input  logic            cfg_sts_w1c,
  input  logic            wuc_wr,
  input  logic            wuc_en_wd,
  input  logic            wuc_sts_w1c,
  input  logic            wake_evt,
  output logic [PS_W-1:0] state,
  output logic [PS_W-1:0] ps_rd,
  output logic            bus_iso,
  output logic            wake_cap,
  output logic            wake_en,
  output logic            wake_sts,
  output logic            pme_req,
  output logic            lp_off
);

  pstate_e st;

  pwr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .bus_rst_n (bus_rst_n),
    .mem_en    (mem_en),
    .ps_wr     (ps_wr),
    .ps_wdata  (ps_wdata),
    .state_q   (st),
    .ps_rd     (ps_rd)
  );

  pwr_wake_regs u_wake (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .bus_rst_n   (bus_rst_n),
    .aux_pwr     (aux_pwr),
    .cfg_wr      (cfg_wr),
    .cfg_en_wd   (cfg_en_wd),
    .cfg_sts_w1c (cfg_sts_w1c),
    .wuc_wr      (wuc_wr),
    .wuc_en_wd   (wuc_en_wd),
    .wuc_sts_w1c (wuc_sts_w1c),
    .wake_evt    (wake_evt),
    .wake_en     (wake_en),
    .wake_sts    (wake_sts),
    .pme_req     (pme_req)
  );

  pwr_adv u_adv (
    .state_q     (st),
    .aux_pwr     (aux_pwr),
    .deep_off_en (deep_off_en),
    .wake_cap    (wake_cap),
    .bus_iso     (bus_iso),
    .lp_off      (lp_off)
  );

  assign state = st;

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk
  import pwr_state_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            pwr_good,
  input logic            bus_rst_n,
  input logic            aux_pwr,
  input logic            deep_off_en,
  input logic            mem_en,
  input logic            ps_wr,
  input logic [PS_W-1:0] ps_wdata,
  input logic            cfg_wr,
  input logic            wuc_wr,
  input logic            wake_evt,
  input logic [PS_W-1:0] state,
  input logic            bus_iso,
  input logic            wake_en,
  input logic            wake_sts,
  input logic            pme_req,
  input logic            lp_off
);

  logic pv;
  logic bus_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv       <= 1'b0;
      bus_prev <= 1'b0;
    end else begin
      pv       <= 1'b1;
      bus_prev <= bus_rst_n;
    end
  end

  AST_BUSRST_TO_DR: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n |=> state == PS_DR); // R2

  AST_PGOOD_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (state == PS_DR) && !wake_en && !wake_sts); // R3

  AST_DR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_DR) && bus_rst_n && pwr_good |=> state == PS_D0U); // R4

  AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ps_wr && (ps_wdata == 2'b01 || ps_wdata == 2'b10) && bus_rst_n && pwr_good
    && (state != PS_DR) && !((state == PS_D0U) && mem_en) |=> $stable(state)); // R6

  AST_ISO_ONLY_DR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_iso |-> state == PS_DR); // R7

  AST_AUX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    pv && aux_pwr && pwr_good && bus_rst_n && !bus_prev && !cfg_wr && !wuc_wr && !wake_evt
    |=> $stable(wake_en) && $stable(wake_sts)); // R9

  AST_AUX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pv && !aux_pwr && bus_rst_n && !bus_prev |=> !wake_en && !wake_sts); // R10

  AST_PME_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    pme_req |-> wake_en && wake_sts); // R12

  AST_LPOFF_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    lp_off |-> deep_off_en && bus_iso); // R13

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (.*);

// File: tb/pwr_state_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb;

  logic       clk;
  logic       rst_n, pwr_good, bus_rst_n, aux_pwr, deep_off_en, mem_en;
  logic       ps_wr;
  logic [1:0] ps_wdata;
  logic       cfg_wr, cfg_en_wd, cfg_sts_w1c;
  logic       wuc_wr, wuc_en_wd, wuc_sts_w1c, wake_evt;
  logic [1:0] state, ps_rd;
  logic       bus_iso, wake_cap, wake_en, wake_sts, pme_req, lp_off;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  localparam logic [1:0] S_DR = 2'd0, S_D0U = 2'd1, S_D0A = 2'd2, S_D3 = 2'd3;

  pwr_state_ctrl u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ps(input logic [1:0] v);
    ps_wr = 1'b1; ps_wdata = v;
    step();
    ps_wr = 1'b0;
  endtask

  task automatic pulse_evt();
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwr_good = 1'b0; bus_rst_n = 1'b0; aux_pwr = 1'b0;
    deep_off_en = 1'b0; mem_en = 1'b0; ps_wr = 1'b0; ps_wdata = 2'b00;
    cfg_wr = 1'b0; cfg_en_wd = 1'b0; cfg_sts_w1c = 1'b0;
    wuc_wr = 1'b0; wuc_en_wd = 1'b0; wuc_sts_w1c = 1'b0; wake_evt = 1'b0;
    step(); step();
    chk("R1 reset state", state, S_DR);
    chk("R1 reset wake_en", wake_en, 0);
    chk("R1 reset wake_sts", wake_sts, 0);
    chk("R7 iso in reset", bus_iso, 1);
    rst_n = 1'b1; pwr_good = 1'b1; bus_rst_n = 1'b1;
    step();
    chk("R4 leave reset state", state, S_D0U);
    chk("R7 iso off", bus_iso, 0);
    chk("R6 readback D0u", ps_rd, 0);
  endtask

  task automatic t_mem();
    step();
    chk("R5 stays D0u without mem_en", state, S_D0U);
    mem_en = 1'b1; step();
    chk("R5 mem_en to D0a", state, S_D0A);
    chk("R6 readback D0a", ps_rd, 0);
    mem_en = 1'b0; step();
    chk("R5 D0a holds", state, S_D0A);
  endtask

  task automatic t_pswrite();
    wr_ps(2'b01);
    chk("R6 01 ignored", state, S_D0A);
    wr_ps(2'b00);
    chk("R6 00 in D0a ignored", state, S_D0A);
    wr_ps(2'b11);
    chk("R6 11 to D3", state, S_D3);
    chk("R6 readback D3", ps_rd, 3);
    wr_ps(2'b10);
    chk("R6 10 ignored in D3", state, S_D3);
    mem_en = 1'b1; step(); mem_en = 1'b0;
    chk("R5 mem_en no effect in D3", state, S_D3);
    wr_ps(2'b00);
    chk("R6 00 back to D0u", state, S_D0U);
  endtask

  task automatic t_busrst();
    wr_ps(2'b11);
    chk("R6 D0u 11 to D3", state, S_D3);
    bus_rst_n = 1'b0; step();
    chk("R2 D3 to Dr", state, S_DR);
    chk("R7 iso in Dr", bus_iso, 1);
    chk("R6 readback Dr", ps_rd, 3);
    wr_ps(2'b00);
    chk("R2 held in Dr", state, S_DR);
    bus_rst_n = 1'b1; step();
    chk("R4 Dr to D0u", state, S_D0U);
  endtask

  task automatic t_aux();
    aux_pwr = 1'b1; #1;
    chk("R8 cap high", wake_cap, 1);
    aux_pwr = 1'b0; #1;
    chk("R8 cap low", wake_cap, 0);
  endtask

  task automatic t_wake();
    cfg_wr = 1'b1; cfg_en_wd = 1'b1; step(); cfg_wr = 1'b0;
    chk("R11 cfg enable write", wake_en, 1);
    chk("R12 no req without status", pme_req, 0);
    pulse_evt();
    chk("R11 event sets status", wake_sts, 1);
    chk("R12 request", pme_req, 1);
    wuc_wr = 1'b1; wuc_en_wd = 1'b1; wuc_sts_w1c = 1'b1; wake_evt = 1'b1;
    step();
    wuc_wr = 1'b0; wuc_sts_w1c = 1'b0; wake_evt = 1'b0;
    chk("R11 event beats clear", wake_sts, 1);
    wuc_wr = 1'b1; wuc_sts_w1c = 1'b1; step(); wuc_wr = 1'b0; wuc_sts_w1c = 1'b0;
    chk("R11 shadow w1c", wake_sts, 0);
    chk("R12 request drops", pme_req, 0);
    wuc_wr = 1'b1; wuc_en_wd = 1'b0; step(); wuc_wr = 1'b0;
    chk("R11 shadow enable write", wake_en, 0);
    cfg_wr = 1'b1; cfg_en_wd = 1'b1; wuc_wr = 1'b1; wuc_en_wd = 1'b0;
    step(); cfg_wr = 1'b0; wuc_wr = 1'b0;
    chk("R11 cfg view wins", wake_en, 1);
    pulse_evt();
    cfg_wr = 1'b1; cfg_en_wd = 1'b1; cfg_sts_w1c = 1'b1; step();
    cfg_wr = 1'b0; cfg_sts_w1c = 1'b0;
    chk("R11 cfg w1c", wake_sts, 0);
  endtask

  task automatic t_aux_keep();
    pulse_evt();
    aux_pwr = 1'b1;
    bus_rst_n = 1'b0; step();
    chk("R9 bits kept during reset", wake_en + wake_sts, 2);
    bus_rst_n = 1'b1; step();
    chk("R9 en kept after release", wake_en, 1);
    chk("R9 sts kept after release", wake_sts, 1);
    chk("R4 back to D0u", state, S_D0U);
  endtask

  task automatic t_aux_clear();
    aux_pwr = 1'b0;
    bus_rst_n = 1'b0; step(); step();
    chk("R10 not cleared while held", wake_en + wake_sts, 2);
    bus_rst_n = 1'b1; step();
    chk("R10 en cleared on rise", wake_en, 0);
    chk("R10 sts cleared on rise", wake_sts, 0);
  endtask

  task automatic t_pgood();
    cfg_wr = 1'b1; cfg_en_wd = 1'b1; step(); cfg_wr = 1'b0;
    pulse_evt();
    aux_pwr = 1'b1;
    pwr_good = 1'b0; step();
    chk("R3 power loss to Dr", state, S_DR);
    chk("R3 wipes en despite aux", wake_en, 0);
    chk("R3 wipes sts", wake_sts, 0);
    pwr_good = 1'b1; step();
    chk("R4 power back D0u", state, S_D0U);
    aux_pwr = 1'b0;
  endtask

  task automatic t_lpoff();
    deep_off_en = 1'b1; #1;
    chk("R13 off outside Dr", lp_off, 0);
    bus_rst_n = 1'b0; step();
    chk("R13 on in Dr", lp_off, 1);
    deep_off_en = 1'b0; #1;
    chk("R13 needs enable", lp_off, 0);
    bus_rst_n = 1'b1; step();
  endtask

  initial begin
    t_reset();
    t_mem();
    t_pswrite();
    t_busrst();
    t_aux();
    t_wake();
    t_aux_keep();
    t_aux_clear();
    t_pgood();
    t_lpoff();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule